// File: doc/BRIEF.md
# Flash Linear Read FIFO Engine

This block streams a contiguous range of serial NOR flash into a 32-bit word FIFO that a host drains over a simple register bus. Software writes a start byte address, a word count and a fill watermark, hands the flash pins to the engine through an ownership bit, and pulses a start bit. The engine then pulls bytes one at a time through a request/valid flash byte port. It packs each group of four bytes into a word, with the first byte in the low bits, and pushes the word into a 64-word FIFO.

Five sticky interrupt status bits report progress and misuse: the fill level reaching the watermark, a session cut short by a clear, a read of an empty FIFO while a session is running, the end of a session, and a read of an empty FIFO while idle. Each bit is cleared by writing one to it. A mask register selects which bits drive the interrupt line. The serial pin sequencing is modelled by the byte port and is not part of the block.

Bus map by word index on `bus_addr`:

| Index | Access | Purpose |
|---|---|---|
| 0 | write | control pulses: bit 0 start, bit 1 clear |
| 1 | read/write | ownership: bit 0 = 1 means the generic SPI master owns the pins |
| 2 | read | bit 0 busy |
| 3 | read/write | start byte address |
| 4 | read/write | word count |
| 5 | read/write | watermark |
| 6 | read | FIFO status: bit 1 empty |
| 7 | read | pops one word |
| 8 | read/write-one-to-clear | interrupt status |
| 9 | read/write | interrupt mask |

Top module: `flash_stream_reader`

## Requirements
- R1: After reset, ownership reads 1, busy reads 0, FIFO status bit 1 (empty) reads 1, interrupt status reads 0, and both `fl_req` and `irq` are low.
- R2: A start (control bit 0 = 1, bit 1 = 0) is taken only while busy is 0 and ownership is 0. It sets busy and fetches bytes from the start address upward, one address per accepted byte. A byte is accepted in a cycle where `fl_req` and `fl_valid` are both high. A start while busy, or while ownership is 1, is ignored.
- R3: Each word holds four consecutive flash bytes in little-endian order: the byte at the lowest address sits in bits 7:0, and the byte at the highest address sits in bits 31:24.
- R4: The session length is the word count register clamped to 64 words. A count of 0 ends the session at once, with no fetch.
- R5: Interrupt status bit 3 (done) is set, and busy drops, in the cycle after the last word of the session is pushed.
- R6: A read of index 7 returns the oldest word and removes it from the FIFO. FIFO status bit 1 is 1 exactly when the FIFO holds no word.
- R7: Interrupt status bit 0 (fullness) is set whenever the FIFO level is nonzero and at least the watermark. With a watermark of 0, any stored word sets it.
- R8: A read of index 7 while the FIFO is empty returns 0 and removes nothing. It sets status bit 2 (impatient) if a session is running, and bit 4 (overread) otherwise.
- R9: Control bit 1 (clear) empties the FIFO and ends any session. If a session was running, it also sets status bit 1 (aborted).
- R10: While ownership is 1, `fl_req` stays low and a running session pauses. It resumes without losing bytes when ownership returns to 0.
- R11: While the FIFO holds 64 words, `fl_req` stays low. Fetching continues once a word is popped, and no data is dropped.
- R12: Writing ones to interrupt status clears those bits. `irq` is high exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_sel | input | 1 | register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | register word index |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid in the cycle of the access |
| irq | output | 1 | masked interrupt line |
| fl_req | output | 1 | engine wants the byte at `fl_addr` |
| fl_addr | output | AW | flash byte address |
| fl_valid | input | 1 | `fl_data` holds the requested byte |
| fl_data | input | 8 | flash byte |

## Verification
Sessions are run from different base addresses, so every word carries an address-dependent byte pattern. This pattern exposes byte-order, address-step and off-by-one packing faults. Counts of 0, 2, 4, 8 and 100 separate the immediate-done path, normal completion and the 64-word clamp. A session started on top of an undrained full FIFO separates stalling from dropping. Ownership toggled in the middle of a word, a clear in the middle of a session, and empty-FIFO reads made both during a session and while idle tell the pause, abort, impatient and overread paths apart. Two watermark sessions, one below and one above the threshold, show that fullness follows the level rather than session completion.

// File: rtl/flash_stream_reader.sv
module flash_stream_reader #(
  parameter int AW = 32,
  parameter int DEPTH = 64,
  parameter int MAX_WORDS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [3:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          fl_req,
  output logic [AW-1:0] fl_addr,
  input  logic          fl_valid,
  input  logic [7:0]    fl_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(MAX_WORDS + 1);

  logic          owner, busy;
  logic [AW-1:0] base_addr;
  logic [CW-1:0] cnt_reg, left;
  logic [LW-1:0] wm_reg, level;
  logic [4:0]    irq_st, irq_mask, st_set;
  logic [1:0]    bsel;
  logic [23:0]   pack;
  logic [PW-1:0] wp, rp;
  logic [31:0]   mem [DEPTH];

  wire wr       = bus_sel & bus_wr;
  wire rd       = bus_sel & ~bus_wr;
  wire wr_ctrl  = wr && bus_addr == 4'd0;
  wire clear    = wr_ctrl & bus_wdata[1];
  wire start    = wr_ctrl & bus_wdata[0] & ~bus_wdata[1];
  wire go       = start & ~busy & ~owner;
  wire empty    = level == '0;
  wire full     = level == LW'(DEPTH);
  wire take     = fl_req & fl_valid;
  wire push     = take && bsel == 2'd3;
  wire rd_pop   = rd && bus_addr == 4'd7;
  wire pop      = rd_pop & ~empty;
  wire bad_pop  = rd_pop & empty;
  wire last     = push && left == CW'(1);
  wire [CW-1:0] eff_cnt = (cnt_reg > CW'(MAX_WORDS)) ? CW'(MAX_WORDS) : cnt_reg;

  assign fl_req = busy & ~owner & ~full;
  assign irq    = |(irq_st & irq_mask);

  assign st_set[0] = ~empty && level >= wm_reg;
  assign st_set[1] = clear & busy;
  assign st_set[2] = bad_pop & busy;
  assign st_set[3] = (last & ~clear) | (go && eff_cnt == '0);
  assign st_set[4] = bad_pop & ~busy;

  always_comb begin
    case (bus_addr)
      4'd1:    bus_rdata = {31'd0, owner};
      4'd2:    bus_rdata = {31'd0, busy};
      4'd3:    bus_rdata = 32'(base_addr);
      4'd4:    bus_rdata = 32'(cnt_reg);
      4'd5:    bus_rdata = 32'(wm_reg);
      4'd6:    bus_rdata = {30'd0, empty, 1'b0};
      4'd7:    bus_rdata = empty ? 32'd0 : mem[rp];
      4'd8:    bus_rdata = {27'd0, irq_st};
      4'd9:    bus_rdata = {27'd0, irq_mask};
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner     <= 1'b1;
      base_addr <= '0;
      cnt_reg   <= '0;
      wm_reg    <= '0;
      irq_mask  <= '0;
      irq_st    <= '0;
    end else begin
      if (wr && bus_addr == 4'd1) owner     <= bus_wdata[0];
      if (wr && bus_addr == 4'd3) base_addr <= bus_wdata[AW-1:0];
      if (wr && bus_addr == 4'd4) cnt_reg   <= bus_wdata[CW-1:0];
      if (wr && bus_addr == 4'd5) wm_reg    <= bus_wdata[LW-1:0];
      if (wr && bus_addr == 4'd9) irq_mask  <= bus_wdata[4:0];
      irq_st <= (irq_st & ~((wr && bus_addr == 4'd8) ? bus_wdata[4:0] : 5'd0)) | st_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      left    <= '0;
      fl_addr <= '0;
      bsel    <= '0;
      pack    <= '0;
    end else if (clear) begin
      busy <= 1'b0;
      bsel <= '0;
    end else if (go) begin
      busy    <= eff_cnt != '0;
      left    <= eff_cnt;
      fl_addr <= base_addr;
      bsel    <= '0;
    end else if (take) begin
      fl_addr <= fl_addr + 1'b1;
      bsel    <= bsel + 1'b1;
      if (bsel != 2'd3) pack[{bsel, 3'b000} +: 8] <= fl_data;
      if (push) left <= left - 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clear) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      level <= level + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wp] <= {fl_data, pack};
  end

  // R10
  owner_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 4'd1 && bus_wdata[0]) |=> !fl_req);
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level < LW'(DEPTH)));
  // R5
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !clear) |=> (!busy && irq_st[3]));
  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (level == '0 && !busy));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pop |=> (irq_st[2] || irq_st[4]));
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |=> (fl_addr == $past(fl_addr) + 1'b1));
endmodule

// File: tb/flash_stream_reader_bench.sv
`timescale 1ns/1ps
module flash_stream_reader_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, fl_req, fl_valid;
  logic [31:0] fl_addr;
  logic [7:0] fl_data;
  int checks = 0, fails = 0;
  bit finished = 0;

  flash_stream_reader u_flash_stream_reader (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_valid(fl_valid), .fl_data(fl_data));

  function automatic logic [7:0] fb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [31:0] fw(input logic [31:0] a);
    return {fb(a + 3), fb(a + 2), fb(a + 1), fb(a)};
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin fl_valid <= 1'b0; fl_data <= 8'd0; end
    else begin fl_valid <= fl_req && !fl_valid; fl_data <= fb(fl_addr); end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 4000; i++) begin
      rd(4'd2, d);
      if (d[0] == 1'b0) return;
    end
    check({tag, " busy never dropped"}, 32'd1, 32'd0);
  endtask

  task automatic drain(input string tag, input logic [31:0] base, input int first, input int n);
    logic [31:0] d;
    for (int k = first; k < first + n; k++) begin
      rd(4'd7, d);
      check(tag, d, fw(base + 32'(4 * k)));
    end
  endtask

  task automatic session(input logic [31:0] base, input logic [31:0] cnt);
    wr(4'd3, base); wr(4'd4, cnt); wr(4'd0, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'd1, d); check("R1 owner", d, 32'd1);
    rd(4'd2, d); check("R1 busy", d, 32'd0);
    rd(4'd6, d); check("R1 empty", d, 32'd2);
    rd(4'd8, d); check("R1 irq status", d, 32'd0);
    check("R1 fl_req/irq", {30'd0, fl_req, irq}, 32'd0);
  endtask

  task automatic t_owner_block;
    logic [31:0] d;
    wr(4'd9, 32'h1F);
    session(32'h100, 32'd4);
    repeat (10) @(posedge clk);
    #1 check("R2 R10 start ignored while master owns pins", {31'd0, fl_req}, 32'd0);
    rd(4'd2, d); check("R2 busy stays low", d, 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    wr(4'd1, 32'd0); wr(4'd5, 32'd0);
    session(32'h100, 32'd4);
    rd(4'd2, d); check("R2 busy after start", d, 32'd1);
    wr(4'd0, 32'd1);
    wait_idle("R5");
    rd(4'd8, d); check("R5 R7 done and fullness", d & 32'h9, 32'h9);
    #1 check("R12 irq high", {31'd0, irq}, 32'd1);
    rd(4'd6, d); check("R6 not empty", d, 32'd0);
    drain("R3 R2 R6 word", 32'h100, 0, 4);
    rd(4'd6, d); check("R6 empty after drain", d, 32'd2);
    wr(4'd8, 32'h1F);
    rd(4'd8, d); check("R12 w1c", d, 32'd0);
    #1 check("R12 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(4'd9, 32'h08);
    rd(4'd7, d); check("R8 overread data", d, 32'd0);
    rd(4'd8, d); check("R8 overread bit", d, 32'h10);
    #1 check("R12 masked bit keeps irq low", {31'd0, irq}, 32'd0);
    wr(4'd9, 32'h1F);
    #1 check("R12 unmasked irq high", {31'd0, irq}, 32'd1);
    wr(4'd8, 32'h1F);
  endtask

  task automatic t_impatient;
    logic [31:0] d;
    session(32'h200, 32'd8);
    rd(4'd7, d); check("R8 impatient data", d, 32'd0);
    rd(4'd8, d); check("R8 impatient bit only", d & 32'h14, 32'h04);
    wait_idle("R8");
    drain("R8 R3 word after impatient", 32'h200, 0, 8);
    wr(4'd8, 32'h1F);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    session(32'h300, 32'd0);
    rd(4'd8, d); check("R4 count zero done", d & 32'h8, 32'h8);
    rd(4'd2, d); check("R4 count zero not busy", d, 32'd0);
    rd(4'd6, d); check("R4 count zero empty", d, 32'd2);
    wr(4'd8, 32'h1F);
  endtask

  task automatic t_watermark;
    logic [31:0] d;
    wr(4'd5, 32'd3);
    session(32'h500, 32'd2);
    wait_idle("R7");
    rd(4'd8, d); check("R7 below watermark", d & 32'h1, 32'h0);
    wr(4'd8, 32'h1F);
    session(32'h508, 32'd2);
    wait_idle("R7");
    rd(4'd8, d); check("R7 at watermark", d & 32'h1, 32'h1);
    drain("R7 word", 32'h500, 0, 4);
    wr(4'd5, 32'd0); wr(4'd8, 32'h1F);
  endtask

  task automatic t_clamp_full;
    logic [31:0] d;
    session(32'h2000, 32'd100);
    wait_idle("R4");
    session(32'h3000, 32'd2);
    repeat (12) @(posedge clk);
    #1 check("R11 no request when full", {31'd0, fl_req}, 32'd0);
    rd(4'd2, d); check("R11 session held", d, 32'd1);
    drain("R4 R11 clamped word", 32'h2000, 0, 2);
    wait_idle("R11");
    drain("R4 clamped word", 32'h2000, 2, 62);
    drain("R11 stalled word", 32'h3000, 0, 2);
    rd(4'd6, d); check("R4 exactly 64 plus 2", d, 32'd2);
    wr(4'd8, 32'h1F);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    session(32'h600, 32'd16);
    repeat (20) @(posedge clk);
    wr(4'd0, 32'd2);
    rd(4'd2, d); check("R9 not busy", d, 32'd0);
    rd(4'd6, d); check("R9 empty", d, 32'd2);
    rd(4'd8, d); check("R9 aborted", d & 32'h2, 32'h2);
    wr(4'd8, 32'h1F);
    wr(4'd0, 32'd2);
    rd(4'd8, d); check("R9 idle clear no abort", d & 32'h2, 32'h0);
  endtask

  task automatic t_pause;
    logic [31:0] d;
    session(32'h700, 32'd4);
    repeat (5) @(posedge clk);
    wr(4'd1, 32'd1);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 check("R10 paused", {31'd0, fl_req}, 32'd0);
    end
    rd(4'd2, d); check("R10 still busy", d, 32'd1);
    wr(4'd0, 32'd1);
    wr(4'd1, 32'd0);
    wait_idle("R10");
    drain("R10 word after pause", 32'h700, 0, 4);
    rd(4'd6, d); check("R2 restart while busy ignored", d, 32'd2);
    wr(4'd8, 32'h1F);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_owner_block();
    t_basic();
    t_mask();
    t_impatient();
    t_zero();
    t_watermark();
    t_clamp_full();
    t_clear();
    t_pause();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule